// File: doc/BRIEF.md
# Interlaced Composite Sync Generator

This block produces every horizontal and vertical timing reference that a monochrome interlaced camera needs, all from a single master clock. A half-line pixel counter and a half-line index together mark each position in the frame. Registered output logic decodes that position into five signals: a line-rate drive pulse, a field-rate drive pulse, composite sync, composite blanking and a field flag. Composite sync carries equalising pulses and a serrated vertical interval.

Two static mode inputs select the line standard and the sensor width class. The line standard is 525 or 625 lines per frame. The sensor class is the narrow 510-pixel class or the wide 760-pixel class. Together they set the clocks per line, every pulse width and the lengths of the vertical intervals.

A frame has an odd number of lines. Because of this, the odd field begins on a line boundary and the even field begins half a line later. A synchronous active-low reset and a restart strobe both return the frame position to its first clock.

Top module: `interlace_sync_gen`

## Requirements
- R1: A line lasts 606 clocks in the narrow class, 910 clocks for 525 lines in the wide class, and 908 clocks for 625 lines in the wide class. hd_n falls once per line.
- R2: Each field lasts LINES_A (std_sel=0) or LINES_B (std_sel=1) half-lines, so that vd_n falls every field-half-lines × half-line clocks. Defaults are 525 and 625.
- R3: At the start of every line, hd_n (active low) stays low for 45 clocks in the narrow class (wide_sel=0) and 68 clocks in the wide class (wide_sel=1).
- R4: The vertical sync region spans 18 half-lines (525) or 15 half-lines (625). Its first and last thirds carry equalising pulses on csync_n at the start of every half-line, 22 clocks (narrow) or 34 clocks (wide) long.
- R5: In the middle third of the vertical sync region, csync_n is low from the start of each half-line for the half-line length minus the R3 width, and vd_n is low for exactly that third.
- R6: cblank_n is low for the first 40 half-lines (525) or 50 half-lines (625) of each field. It is also low at the start of every line for 104/114 clocks (narrow, 525/625) or 154/169 clocks (wide, 525/625).
- R7: The odd field starts on a line boundary and the even field starts at the middle of a line. field_odd rises when vd_n falls in the odd field and falls when vd_n falls in the even field.
- R8: csync_n is never low while cblank_n is high.
- R9: While rst_n is low at a clock edge, the next outputs are hd_n, vd_n, csync_n and cblank_n high and field_odd low. After release, the outputs follow the position with one clock of latency, starting from the first clock of the odd field.
- R10: When restart is high at a clock edge, the frame position returns to the first clock of the odd field. The next vd_n fall follows one sync-region third of half-lines later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Strobe returning the frame position to its start |
| std_sel | input | 1 | Line standard: 0 = 525 lines, 1 = 625 lines |
| wide_sel | input | 1 | Sensor class: 0 = 510-pixel, 1 = 760-pixel |
| hd_n | output | 1 | Line drive pulse, active low |
| vd_n | output | 1 | Field drive pulse, active low |
| csync_n | output | 1 | Composite sync, active low |
| cblank_n | output | 1 | Composite blanking, active low |
| field_odd | output | 1 | High during the odd field, changing at each vd_n fall |

## Verification
Some properties are checked on every clock by the assertions. Sync pulses never leave the blanking interval, and vd_n lies inside vertical blanking. The field flag flips at each vd_n fall. The half-line index advances by one at each half-line wrap, and a restart zeroes both counters. The bench's reference scoreboard is what shows the exact values: pulse widths per mode, equalising and serrated patterns, hd_n and vd_n periods, the half-line offset of the even field, the reset state, and the timing of the first field after a restart.

// File: rtl/isg_pkg.sv
package isg_pkg;

   localparam int TCW = 16;

   typedef logic [TCW-1:0] tcount_t;

   typedef enum logic {
      STD_525 = 1'b0,
      STD_625 = 1'b1
   } line_std_e;

   typedef enum logic {
      SENS_NARROW = 1'b0,
      SENS_WIDE   = 1'b1
   } sensor_e;

   // Per-mode timing numbers, all counted in master clocks or half-lines
   typedef struct packed {
      tcount_t half_len;   // clocks per half-line
      tcount_t hs_w;       // line sync width
      tcount_t eq_w;       // equalising pulse width
      tcount_t hblank;     // horizontal blanking width
      tcount_t field_hl;   // half-lines per field (= lines per frame)
      tcount_t vs_third;   // half-lines in one third of the sync region
      tcount_t vb_hl;      // half-lines of vertical blanking per field
   } timing_t;

   typedef struct packed {
      logic hd_n;
      logic vd_n;
      logic csync_n;
      logic cblank_n;
      logic field_odd;
   } sync_out_t;

endpackage

// File: rtl/isg_mode_decode.sv
module isg_mode_decode
   import isg_pkg::*;
#(
   parameter int LINES_A        = 525,
   parameter int LINES_B        = 625,
   parameter int HALF_NARROW    = 303,
   parameter int HALF_WIDE_A    = 455,
   parameter int HALF_WIDE_B    = 454,
   parameter int HS_NARROW      = 45,
   parameter int HS_WIDE        = 68,
   parameter int EQ_NARROW      = 22,
   parameter int EQ_WIDE        = 34,
   parameter int HBLK_NARROW_A  = 104,
   parameter int HBLK_NARROW_B  = 114,
   parameter int HBLK_WIDE_A    = 154,
   parameter int HBLK_WIDE_B    = 169,
   parameter int VSYNC_HL_A     = 18,
   parameter int VSYNC_HL_B     = 15,
   parameter int VBLANK_LINES_A = 20,
   parameter int VBLANK_LINES_B = 25
) (
   input  line_std_e std_sel,
   input  sensor_e   sens_sel,
   output timing_t   cfg
);

   localparam tcount_t THIRD_A = tcount_t'(VSYNC_HL_A / 3);
   localparam tcount_t THIRD_B = tcount_t'(VSYNC_HL_B / 3);
   localparam tcount_t VB_HL_A = tcount_t'(2 * VBLANK_LINES_A);
   localparam tcount_t VB_HL_B = tcount_t'(2 * VBLANK_LINES_B);

   always_comb begin
      cfg = '0;
      // standard-dependent vertical numbers
      if (std_sel == STD_625) begin
         cfg.field_hl = tcount_t'(LINES_B);
         cfg.vs_third = THIRD_B;
         cfg.vb_hl    = VB_HL_B;
      end else begin
         cfg.field_hl = tcount_t'(LINES_A);
         cfg.vs_third = THIRD_A;
         cfg.vb_hl    = VB_HL_A;
      end
      // sensor-class (and combined) horizontal numbers
      if (sens_sel == SENS_WIDE) begin
         cfg.hs_w = tcount_t'(HS_WIDE);
         cfg.eq_w = tcount_t'(EQ_WIDE);
         if (std_sel == STD_625) begin
            cfg.half_len = tcount_t'(HALF_WIDE_B);
            cfg.hblank   = tcount_t'(HBLK_WIDE_B);
         end else begin
            cfg.half_len = tcount_t'(HALF_WIDE_A);
            cfg.hblank   = tcount_t'(HBLK_WIDE_A);
         end
      end else begin
         cfg.hs_w     = tcount_t'(HS_NARROW);
         cfg.eq_w     = tcount_t'(EQ_NARROW);
         cfg.half_len = tcount_t'(HALF_NARROW);
         cfg.hblank   = (std_sel == STD_625) ? tcount_t'(HBLK_NARROW_B)
                                             : tcount_t'(HBLK_NARROW_A);
      end
   end

endmodule

// File: rtl/isg_halfline_counter.sv
module isg_halfline_counter
   import isg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    restart,
   input  tcount_t half_len,
   input  tcount_t field_hl,
   output tcount_t pos,
   output tcount_t hl_idx
);

   tcount_t frame_hl;
   tcount_t pos_last;
   tcount_t hl_last;

   assign frame_hl = {field_hl[TCW-2:0], 1'b0};
   assign pos_last = half_len - tcount_t'(1);
   assign hl_last  = frame_hl - tcount_t'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         pos    <= '0;
         hl_idx <= '0;
      end else if (pos >= pos_last) begin
         pos <= '0;
         if (hl_idx >= hl_last) hl_idx <= '0;
         else                   hl_idx <= hl_idx + tcount_t'(1);
      end else begin
         pos <= pos + tcount_t'(1);
      end
   end

   // R10: a restart strobe lands on the first clock of the odd field
   p_restart_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pos == '0 && hl_idx == '0));

   // R2: half-line index steps by one at each half-line wrap inside the frame
   p_hl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && pos == pos_last && hl_idx < hl_last)
      |=> (hl_idx == $past(hl_idx) + tcount_t'(1)));

   // R1: the pixel position wraps to zero after the last clock of a half-line
   p_pos_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && pos == pos_last) |=> (pos == '0));

endmodule

// File: rtl/isg_sync_shaper.sv
module isg_sync_shaper
   import isg_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  timing_t   cfg,
   input  tcount_t   pos,
   input  tcount_t   hl_idx,
   output sync_out_t outs
);

   localparam sync_out_t IDLE = '{hd_n: 1'b1, vd_n: 1'b1, csync_n: 1'b1,
                                  cblank_n: 1'b1, field_odd: 1'b0};

   tcount_t   fpos;
   tcount_t   thr2;
   tcount_t   thr3;
   tcount_t   serr_lim;
   tcount_t   odd_end;
   logic      line_head;
   logic      in_serr;
   logic      in_eq;
   logic      sync_low;
   sync_out_t nxt;

   always_comb begin
      thr2      = cfg.vs_third + cfg.vs_third;
      thr3      = thr2 + cfg.vs_third;
      serr_lim  = cfg.half_len - cfg.hs_w;
      odd_end   = cfg.field_hl + cfg.vs_third;
      // even field begins at an odd half-line index
      fpos      = (hl_idx >= cfg.field_hl) ? (hl_idx - cfg.field_hl) : hl_idx;
      line_head = ~hl_idx[0];
      in_serr   = (fpos >= cfg.vs_third) && (fpos < thr2);
      in_eq     = !in_serr && (fpos < thr3);

      if (in_serr)    sync_low = pos < serr_lim;
      else if (in_eq) sync_low = pos < cfg.eq_w;
      else            sync_low = line_head && (pos < cfg.hs_w);

      nxt.hd_n      = !(line_head && (pos < cfg.hs_w));
      nxt.vd_n      = !in_serr;
      nxt.csync_n   = !sync_low;
      nxt.cblank_n  = !((fpos < cfg.vb_hl) || (line_head && (pos < cfg.hblank)));
      nxt.field_odd = (hl_idx >= cfg.vs_third) && (hl_idx < odd_end);
   end

   if (OUT_REG) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) outs <= IDLE;
         else        outs <= nxt;
      end
   end else begin : g_comb_out
      assign outs = rst_n ? nxt : IDLE;
   end

endmodule

// File: rtl/interlace_sync_gen.sv
module interlace_sync_gen
   import isg_pkg::*;
#(
   parameter int LINES_A        = 525,
   parameter int LINES_B        = 625,
   parameter int HALF_NARROW    = 303,
   parameter int HALF_WIDE_A    = 455,
   parameter int HALF_WIDE_B    = 454,
   parameter int HS_NARROW      = 45,
   parameter int HS_WIDE        = 68,
   parameter int EQ_NARROW      = 22,
   parameter int EQ_WIDE        = 34,
   parameter int HBLK_NARROW_A  = 104,
   parameter int HBLK_NARROW_B  = 114,
   parameter int HBLK_WIDE_A    = 154,
   parameter int HBLK_WIDE_B    = 169,
   parameter int VSYNC_HL_A     = 18,
   parameter int VSYNC_HL_B     = 15,
   parameter int VBLANK_LINES_A = 20,
   parameter int VBLANK_LINES_B = 25,
   parameter bit OUT_REG        = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic std_sel,
   input  logic wide_sel,
   output logic hd_n,
   output logic vd_n,
   output logic csync_n,
   output logic cblank_n,
   output logic field_odd
);

   localparam int MAX_LINES = (LINES_A > LINES_B) ? LINES_A : LINES_B;

   // ---------------- elaboration-time parameter checks ----------------
   if ((LINES_A % 2) == 0 || (LINES_B % 2) == 0) begin : g_err_even_frame
      $error("frame line counts must be odd for interlace");
   end
   if ((VSYNC_HL_A % 3) != 0 || (VSYNC_HL_B % 3) != 0) begin : g_err_vs_thirds
      $error("sync region must split into three equal parts");
   end
   if (2 * MAX_LINES >= (1 << TCW)) begin : g_err_width
      $error("frame half-line count exceeds counter width");
   end
   if (2 * VBLANK_LINES_A > LINES_A || 2 * VBLANK_LINES_B > LINES_B) begin : g_err_vblank
      $error("vertical blanking longer than a field");
   end
   if (VSYNC_HL_A > 2 * VBLANK_LINES_A || VSYNC_HL_B > 2 * VBLANK_LINES_B) begin : g_err_vsync
      $error("sync region must lie inside vertical blanking");
   end
   if (HS_NARROW >= HBLK_NARROW_A || HS_NARROW >= HBLK_NARROW_B ||
       HS_WIDE >= HBLK_WIDE_A || HS_WIDE >= HBLK_WIDE_B) begin : g_err_hs
      $error("line sync must be shorter than horizontal blanking");
   end
   if (HBLK_NARROW_B >= HALF_NARROW || HBLK_WIDE_A >= HALF_WIDE_A ||
       HBLK_WIDE_B >= HALF_WIDE_B) begin : g_err_hblank
      $error("horizontal blanking must fit in a half-line");
   end
   if (EQ_NARROW >= HS_NARROW || EQ_WIDE >= HS_WIDE) begin : g_err_eq
      $error("equalising pulse must be narrower than line sync");
   end

   // ---------------- datapath ----------------
   timing_t   cfg;
   tcount_t   pos;
   tcount_t   hl_idx;
   sync_out_t outs;

   isg_mode_decode #(
      .LINES_A       (LINES_A),
      .LINES_B       (LINES_B),
      .HALF_NARROW   (HALF_NARROW),
      .HALF_WIDE_A   (HALF_WIDE_A),
      .HALF_WIDE_B   (HALF_WIDE_B),
      .HS_NARROW     (HS_NARROW),
      .HS_WIDE       (HS_WIDE),
      .EQ_NARROW     (EQ_NARROW),
      .EQ_WIDE       (EQ_WIDE),
      .HBLK_NARROW_A (HBLK_NARROW_A),
      .HBLK_NARROW_B (HBLK_NARROW_B),
      .HBLK_WIDE_A   (HBLK_WIDE_A),
      .HBLK_WIDE_B   (HBLK_WIDE_B),
      .VSYNC_HL_A    (VSYNC_HL_A),
      .VSYNC_HL_B    (VSYNC_HL_B),
      .VBLANK_LINES_A(VBLANK_LINES_A),
      .VBLANK_LINES_B(VBLANK_LINES_B)
   ) u_decode (
      .std_sel (line_std_e'(std_sel)),
      .sens_sel(sensor_e'(wide_sel)),
      .cfg     (cfg)
   );

   isg_halfline_counter u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .half_len(cfg.half_len),
      .field_hl(cfg.field_hl),
      .pos     (pos),
      .hl_idx  (hl_idx)
   );

   isg_sync_shaper #(
      .OUT_REG(OUT_REG)
   ) u_shape (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg   (cfg),
      .pos   (pos),
      .hl_idx(hl_idx),
      .outs  (outs)
   );

   assign hd_n      = outs.hd_n;
   assign vd_n      = outs.vd_n;
   assign csync_n   = outs.csync_n;
   assign cblank_n  = outs.cblank_n;
   assign field_odd = outs.field_odd;

   // R8: composite sync only inside composite blanking
   p_sync_in_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !csync_n |-> !cblank_n);

   // R5 / R6: field drive pulse lies inside vertical blanking
   p_vd_in_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !vd_n |-> !cblank_n);

   // R7: the field flag flips at every field drive fall
   p_field_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vd_n) |-> (field_odd != $past(field_odd)));

endmodule

// File: tb/interlace_sync_gen_test.sv
module interlace_sync_gen_test;

   localparam int CLK_PERIOD = 10;
   localparam int T_LINES_A  = 41;   // shortened frames keep the run bounded
   localparam int T_LINES_B  = 51;
   localparam int WATCHDOG   = 190000;

   typedef struct {
      logic hd_n;
      logic vd_n;
      logic csync_n;
      logic cblank_n;
      logic odd;
      int   tag;      // 0 normal, 9 reset, 10 after restart
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic std_sel = 1'b0;
   logic wide_sel = 1'b0;
   logic hd_n, vd_n, csync_n, cblank_n, field_odd;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   exp_t q[$];

   // reference model state: line number and clock inside the line
   int m_line = 0;
   int m_x = 0;
   int rs_win = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   interlace_sync_gen #(
      .LINES_A(T_LINES_A),
      .LINES_B(T_LINES_B)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .std_sel  (std_sel),
      .wide_sel (wide_sel),
      .hd_n     (hd_n),
      .vd_n     (vd_n),
      .csync_n  (csync_n),
      .cblank_n (cblank_n),
      .field_odd(field_odd)
   );

   // ---------------- mode numbers taken from the requirements ----------------
   function automatic int m_half();
      if (!wide_sel) return 303;
      return std_sel ? 454 : 455;
   endfunction
   function automatic int m_lines();
      return std_sel ? T_LINES_B : T_LINES_A;
   endfunction
   function automatic int m_hs();
      return wide_sel ? 68 : 45;
   endfunction
   function automatic int m_eq();
      return wide_sel ? 34 : 22;
   endfunction
   function automatic int m_hblk();
      if (!wide_sel) return std_sel ? 114 : 104;
      return std_sel ? 169 : 154;
   endfunction
   function automatic int m_third();
      return std_sel ? 5 : 6;
   endfunction
   function automatic int m_vb();
      return std_sel ? 50 : 40;
   endfunction

   function automatic exp_t predict(int line, int x, int tag);
      exp_t e;
      int   half = m_half();
      int   lines = m_lines();
      int   th = m_third();
      int   hl = 2 * line + ((x >= half) ? 1 : 0);
      int   p = (x >= half) ? x - half : x;
      int   fp = (hl < lines) ? hl : hl - lines;
      bit   serr = (fp >= th) && (fp < 2 * th);
      bit   eqr = (fp < 3 * th) && !serr;
      bit   cs;
      if (serr)     cs = p < (half - m_hs());
      else if (eqr) cs = p < m_eq();
      else          cs = x < m_hs();
      e.hd_n     = !(x < m_hs());
      e.vd_n     = !serr;
      e.csync_n  = !cs;
      e.cblank_n = !((fp < m_vb()) || (x < m_hblk()));
      e.odd      = (hl >= th) && (hl < lines + th);
      e.tag      = tag;
      return e;
   endfunction

   // driver side: push the value expected after this edge, then advance model
   task automatic push_expected();
      exp_t e;
      if (!rst_n) begin
         e.hd_n = 1'b1; e.vd_n = 1'b1; e.csync_n = 1'b1;
         e.cblank_n = 1'b1; e.odd = 1'b0; e.tag = 9;
         q.push_back(e);
         m_line = 0; m_x = 0;
      end else begin
         q.push_back(predict(m_line, m_x, (rs_win > 0) ? 10 : 0));
         if (rs_win > 0) rs_win--;
         if (restart) begin
            m_line = 0; m_x = 0; rs_win = 2000;
         end else begin
            m_x++;
            if (m_x == 2 * m_half()) begin
               m_x = 0;
               m_line++;
               if (m_line == m_lines()) m_line = 0;
            end
         end
      end
   endtask

   always @(posedge clk) push_expected();

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- monitor ----------------
   int  cyc = 0;
   int  hd_ref = -1;
   int  vd_ref = -1;
   logic prev_hd = 1'b1;
   logic prev_vd = 1'b1;

   always @(negedge clk) begin
      exp_t e;
      cyc++;
      if (q.size() > 0) begin
         e = q.pop_front();
         if (e.tag == 9) begin
            check(hd_n === e.hd_n && vd_n === e.vd_n && csync_n === e.csync_n &&
                  cblank_n === e.cblank_n && field_odd === e.odd, "R9", "reset state",
                  {hd_n, vd_n, csync_n, cblank_n, field_odd},
                  {e.hd_n, e.vd_n, e.csync_n, e.cblank_n, e.odd});
            hd_ref = -1; vd_ref = -1;
         end else begin
            if (e.tag == 10) begin
               check(vd_n === e.vd_n && field_odd === e.odd, "R10", "post-restart field",
                     {vd_n, field_odd}, {e.vd_n, e.odd});
               hd_ref = -1; vd_ref = -1;
            end
            check(hd_n === e.hd_n, "R3", "hd_n", hd_n, e.hd_n);
            check(csync_n === e.csync_n, "R4", "csync_n", csync_n, e.csync_n);
            check(vd_n === e.vd_n, "R5", "vd_n", vd_n, e.vd_n);
            check(cblank_n === e.cblank_n, "R6", "cblank_n", cblank_n, e.cblank_n);
            check(field_odd === e.odd, "R7", "field_odd", field_odd, e.odd);
            check(!(csync_n === 1'b0 && cblank_n === 1'b1), "R8", "sync outside blank",
                  csync_n, cblank_n);
            if (prev_hd === 1'b1 && hd_n === 1'b0) begin
               if (hd_ref >= 0)
                  check(cyc - hd_ref == 2 * m_half(), "R1", "line period",
                        cyc - hd_ref, 2 * m_half());
               hd_ref = cyc;
            end
            if (prev_vd === 1'b1 && vd_n === 1'b0) begin
               if (vd_ref >= 0)
                  check(cyc - vd_ref == m_lines() * m_half(), "R2", "field period",
                        cyc - vd_ref, m_lines() * m_half());
               vd_ref = cyc;
            end
         end
      end
      prev_hd = hd_n;
      prev_vd = vd_n;
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // 525 lines, narrow class: one frame plus wrap
      repeat (T_LINES_A * 606 + 1500) @(negedge clk);
      // 625 lines, narrow class
      std_sel = 1'b1;
      apply_reset();
      repeat (T_LINES_B * 606 + 1000) @(negedge clk);
      // restart strobe in the middle of the frame (R10)
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      repeat (2500) @(negedge clk);
      // 525 lines, wide class
      std_sel = 1'b0;
      wide_sel = 1'b1;
      apply_reset();
      repeat (T_LINES_A * 910 + 1000) @(negedge clk);
      // 625 lines, wide class
      std_sel = 1'b1;
      apply_reset();
      repeat (T_LINES_B * 908 + 1000) @(negedge clk);
      finish_run();
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      finish_run();
   end

endmodule